// File: doc/BRIEF.md
# Binary64 to Unsigned 32-bit Integer Converter

This block takes the bit pattern of an IEEE-754 binary64 number and turns it into an unsigned 32-bit integer, rounding under a mode chosen per operation. The integer is placed in a 64-bit destination the way a 64-bit integer core expects a word result: bit 31 is copied into bits 63:32, even though the value is unsigned. The block also reports the invalid and inexact exception flags.

Conversion is a single registered stage. The operand is split into its fields, the significand is shifted to line up the binary point, and an increment is chosen from the rounding bit, the sticky bit, the sign and the mode. Values outside the 32-bit unsigned range saturate. This covers values that are too large before rounding and values that rounding carries up to 2^32. The output is then widened to 64 bits.

Top module: `dbl2uw_conv`

## Requirements
- R1: `res_vld` equals `op_vld` from the previous clock. While `rst_n` is low at a rising edge, `res_vld`, `res_data` and both flags are cleared on that edge.
- R2: A non-negative operand whose rounded value fits in 32 bits gives that value. `res_data[63:32]` always repeats `res_data[31]`, so the exact operand 2^31 yields 0xFFFFFFFF80000000.
- R3: The rounding-mode encodings are:
  - 0: nearest, ties to even
  - 1: toward zero
  - 2: toward minus infinity
  - 3: toward plus infinity
  - 4: nearest, ties away from zero
- R4: A positive operand that is at least 2^32, or that rounds to 2^32, gives all ones with invalid set and inexact clear.
- R5: A NaN (exponent field all ones, fraction nonzero) or plus infinity gives all ones with invalid set and inexact clear.
- R6: Minus infinity, and any negative operand that rounds to a nonzero magnitude, gives 0 with invalid set and inexact clear.
- R7: A negative operand that rounds to zero gives 0 with invalid clear. Inexact is set only when a nonzero fraction was discarded.
- R8: Inexact is set exactly when discarded fraction bits are nonzero and the result is in range. This includes subnormal operands.
- R9: Rounding-mode codes 5, 6 and 7 give all ones with invalid set and inexact clear, whatever the operand.
- R10: Two results are fixed:
  - Operand 0x41DFFFFFFFC00001 with mode 3 gives 0xFFFFFFFF80000000.
  - Operand 0x41EFFFFFFFFFFFFF with mode 4 gives 0xFFFFFFFFFFFFFFFF with invalid set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_vld | input | 1 | Operand valid strobe |
| op_bits | input | 64 | binary64 operand bit pattern |
| rnd_mode | input | 3 | Rounding-mode code |
| res_vld | output | 1 | Result valid, one clock after `op_vld` |
| res_data | output | 64 | 32-bit result, bit 31 copied into bits 63:32 |
| flag_nv | output | 1 | Invalid-operation flag |
| flag_nx | output | 1 | Inexact flag |

## Verification
The assertions assume that `op_vld`, `op_bits` and `rnd_mode` carry known values at every rising edge, including the edges during reset. They relate the registered result to the operand sampled one edge earlier. The stimulus drives every input from time zero, always on the falling edge, and holds the operand and mode at defined values even in cycles where `op_vld` is low. Random operands are biased toward exponents near the 32-bit boundary, with sign and mode varied, so both the saturation paths and the tie cases are reached.

// File: rtl/dbl2uw_pkg.sv
// Shared widths and the rounding-mode encoding for the binary64 to
// unsigned-word converter. Assumes IEEE-754 binary64 field layout.
package dbl2uw_pkg;
    localparam int FP_W   = 64;
    localparam int EXP_W  = 11;
    localparam int MAN_W  = 52;
    localparam int INT_W  = 32;
    localparam int RES_W  = 64;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int UEXP_W = EXP_W + 2;
    localparam int SH_W   = $clog2(INT_W);

    typedef enum logic [2:0] {
        RM_NEAR_EVEN = 3'd0,
        RM_ZERO      = 3'd1,
        RM_DOWN      = 3'd2,
        RM_UP        = 3'd3,
        RM_NEAR_MAX  = 3'd4
    } rmode_e;
endpackage

// File: rtl/d2u_unpack.sv
// Splits a binary64 pattern into its sign, class and an unbiased exponent
// with the hidden bit restored. Subnormals use exponent 1-BIAS with no
// hidden bit. Assumes binary64 field order: sign, exponent, fraction.
module d2u_unpack
    import dbl2uw_pkg::*;
(
    input  logic [FP_W-1:0]          op,
    output logic                     sign,
    output logic                     is_nan,
    output logic                     is_inf,
    output logic signed [UEXP_W-1:0] uexp,
    output logic [MAN_W:0]           mant
);
    logic [EXP_W-1:0] efld;
    logic [MAN_W-1:0] ffld;

    assign sign = op[FP_W-1];
    assign efld = op[FP_W-2 -: EXP_W];
    assign ffld = op[MAN_W-1:0];

    // Classify special encodings and rebuild the significand.
    always_comb begin
        is_nan = (&efld) && (|ffld);
        is_inf = (&efld) && !(|ffld);
        if (efld == '0) begin
            uexp = UEXP_W'(1 - BIAS);
            mant = {1'b0, ffld};
        end else begin
            uexp = $signed({2'b00, efld}) - UEXP_W'(BIAS);
            mant = {1'b1, ffld};
        end
    end
endmodule

// File: rtl/d2u_align.sv
// Aligns the significand to the integer binary point. Produces the
// truncated integer magnitude, the first discarded bit, the OR of all
// later discarded bits, and a flag for magnitudes of at least 2^INT_W.
module d2u_align
    import dbl2uw_pkg::*;
(
    input  logic signed [UEXP_W-1:0] uexp,
    input  logic [MAN_W:0]           mant,
    output logic [INT_W-1:0]         int_part,
    output logic                     rnd_bit,
    output logic                     sticky,
    output logic                     pre_ovf
);
    localparam int P_W = INT_W + MAN_W + 1;

    logic [P_W-1:0] shifted;

    assign shifted = {{INT_W{1'b0}}, mant} << uexp[SH_W-1:0];

    // Choose between overflow, in-window shift and pure-fraction cases.
    always_comb begin
        int_part = '0;
        rnd_bit  = 1'b0;
        sticky   = 1'b0;
        pre_ovf  = 1'b0;
        if (uexp >= UEXP_W'(INT_W)) begin
            pre_ovf = 1'b1;
        end else if (uexp >= 0) begin
            int_part = shifted[MAN_W+INT_W-1:MAN_W];
            rnd_bit  = shifted[MAN_W-1];
            sticky   = |shifted[MAN_W-2:0];
        end else if (uexp == -1) begin
            rnd_bit = mant[MAN_W];
            sticky  = |mant[MAN_W-1:0];
        end else begin
            sticky  = |mant;
        end
    end
endmodule

// File: rtl/d2u_round_pack.sv
// Applies the rounding increment, saturates out-of-range results, raises
// the exception flags and copies bit INT_W-1 into the upper result bits.
// Assumes the aligned magnitude and guard bits come from d2u_align.
module d2u_round_pack
    import dbl2uw_pkg::*;
(
    input  logic             sign,
    input  logic             is_nan,
    input  logic             is_inf,
    input  logic [2:0]       mode,
    input  logic [INT_W-1:0] int_part,
    input  logic             rnd_bit,
    input  logic             sticky,
    input  logic             pre_ovf,
    output logic [RES_W-1:0] res,
    output logic             nv,
    output logic             nx
);
    logic             inc;
    logic             bad_mode;
    logic             lost;
    logic [INT_W:0]   sum;
    logic [INT_W-1:0] res32;

    assign bad_mode = (mode > 3'(RM_NEAR_MAX));
    assign lost     = rnd_bit | sticky;
    assign sum      = {1'b0, int_part} + (INT_W+1)'(inc);

    // Pick the increment for the selected rounding direction.
    always_comb begin
        case (mode)
            3'(RM_NEAR_EVEN): inc = rnd_bit & (sticky | int_part[0]);
            3'(RM_ZERO):      inc = 1'b0;
            3'(RM_DOWN):      inc = sign & lost;
            3'(RM_UP):        inc = ~sign & lost;
            3'(RM_NEAR_MAX):  inc = rnd_bit;
            default:          inc = 1'b0;
        endcase
    end

    // Resolve specials, saturation and flags in priority order.
    always_comb begin
        res32 = '0;
        nv    = 1'b0;
        nx    = 1'b0;
        if (bad_mode || is_nan) begin
            res32 = '1;
            nv    = 1'b1;
        end else if (is_inf || pre_ovf) begin
            res32 = sign ? '0 : '1;
            nv    = 1'b1;
        end else if (sign) begin
            if (sum != '0) nv = 1'b1;
            else           nx = lost;
        end else if (sum[INT_W]) begin
            res32 = '1;
            nv    = 1'b1;
        end else begin
            res32 = sum[INT_W-1:0];
            nx    = lost;
        end
    end

    assign res = {{(RES_W-INT_W){res32[INT_W-1]}}, res32};
endmodule

// File: rtl/dbl2uw_conv.sv
// Top of the binary64 to unsigned 32-bit converter. One register stage:
// the result appears one clock after the operand. Synchronous active-low
// reset clears valid, data and flags. Inputs are assumed known each edge.
module dbl2uw_conv
    import dbl2uw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_vld,
    input  logic [FP_W-1:0]  op_bits,
    input  logic [2:0]       rnd_mode,
    output logic             res_vld,
    output logic [RES_W-1:0] res_data,
    output logic             flag_nv,
    output logic             flag_nx
);
    logic                     u_sign, u_nan, u_inf;
    logic signed [UEXP_W-1:0] u_exp;
    logic [MAN_W:0]           u_mant;
    logic [INT_W-1:0]         a_int;
    logic                     a_rnd, a_sticky, a_ovf;
    logic [RES_W-1:0]         c_res;
    logic                     c_nv, c_nx;
    logic                     armed;

    d2u_unpack u_unpack (
        .op(op_bits), .sign(u_sign), .is_nan(u_nan), .is_inf(u_inf),
        .uexp(u_exp), .mant(u_mant)
    );

    d2u_align u_align (
        .uexp(u_exp), .mant(u_mant), .int_part(a_int), .rnd_bit(a_rnd),
        .sticky(a_sticky), .pre_ovf(a_ovf)
    );

    d2u_round_pack u_pack (
        .sign(u_sign), .is_nan(u_nan), .is_inf(u_inf), .mode(rnd_mode),
        .int_part(a_int), .rnd_bit(a_rnd), .sticky(a_sticky),
        .pre_ovf(a_ovf), .res(c_res), .nv(c_nv), .nx(c_nx)
    );

    // Output register stage with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_vld  <= 1'b0;
            res_data <= '0;
            flag_nv  <= 1'b0;
            flag_nx  <= 1'b0;
        end else begin
            res_vld  <= op_vld;
            res_data <= c_res;
            flag_nv  <= c_nv;
            flag_nx  <= c_nx;
        end
    end

    // Marks that at least one edge has passed since reset was released.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    p_vld_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (res_vld == $past(op_vld)));

    p_upper_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> (res_data[RES_W-1:INT_W] == {(RES_W-INT_W){res_data[INT_W-1]}}));

    p_flag_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> !(flag_nv && flag_nx));

    p_nan_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && res_vld && $past((&op_bits[62:52]) && (|op_bits[51:0])))
        |-> (flag_nv && (&res_data)));

    p_nv_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && flag_nv) |-> ((res_data == '0) || (&res_data)));

    p_bad_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(op_vld && (rnd_mode > 3'd4)))
        |-> (res_vld && flag_nv && !flag_nx && (&res_data)));
endmodule

// File: tb/sim_dbl2uw_conv.sv
// Bench for dbl2uw_conv: a behavioural model on real arithmetic predicts
// every result; outputs are compared each clock, one step after the edge.
module sim_dbl2uw_conv;
    localparam int CLK_PERIOD = 10;
    localparam real TWO32 = 4294967296.0;

    typedef struct {
        logic [63:0] res;
        logic        nv;
        logic        nx;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_vld = 1'b0;
    logic [63:0] op_bits = '0;
    logic [2:0]  rnd_mode = '0;
    logic        res_vld;
    logic [63:0] res_data;
    logic        flag_nv, flag_nx;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 1'b0;
    exp_t expq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dbl2uw_conv u0 (
        .clk(clk), .rst_n(rst_n), .op_vld(op_vld), .op_bits(op_bits),
        .rnd_mode(rnd_mode), .res_vld(res_vld), .res_data(res_data),
        .flag_nv(flag_nv), .flag_nx(flag_nx)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic exp_t model(input logic [63:0] b, input logic [2:0] m,
                                   input string tag);
        exp_t e;
        real v, fl, ce, r, d;
        logic [31:0] r32;
        e.tag = tag; e.nv = 1'b0; e.nx = 1'b0; r32 = '0;
        v = $bitstoreal(b);
        if (m > 3'd4) begin
            r32 = '1; e.nv = 1'b1;
        end else if (b[62:52] == 11'h7FF) begin
            e.nv = 1'b1;
            r32 = (b[51:0] != 0 || !b[63]) ? '1 : '0;
        end else if (v >= TWO32) begin
            r32 = '1; e.nv = 1'b1;
        end else if (v <= -TWO32) begin
            e.nv = 1'b1;
        end else begin
            fl = $floor(v); ce = $ceil(v); d = v - fl;
            case (m)
                3'd1: r = (v < 0.0) ? ce : fl;
                3'd2: r = fl;
                3'd3: r = ce;
                3'd4: r = (d > 0.5) ? ce : (d < 0.5) ? fl : ((v < 0.0) ? fl : ce);
                default: r = (d > 0.5) ? ce : (d < 0.5) ? fl :
                             (((longint'(fl) & 64'sd1) == 0) ? fl : ce);
            endcase
            if (r >= TWO32) begin
                r32 = '1; e.nv = 1'b1;
            end else if (r <= -1.0) begin
                e.nv = 1'b1;
            end else begin
                r32 = 32'(longint'(r));
                e.nx = (r != v);
            end
        end
        e.res = {{32{r32[31]}}, r32};
        return e;
    endfunction

    // One clock: drive on the falling edge, compare just after the rising edge.
    task automatic step(input bit vld, input logic [63:0] b, input logic [2:0] m,
                        input string tag);
        exp_t e;
        @(negedge clk);
        op_vld = vld; op_bits = b; rnd_mode = m;
        if (vld) expq.push_back(model(b, m, tag));
        @(posedge clk); #1;
        chk(res_vld == vld, "R1 valid", 64'(res_vld), 64'(vld));
        if (vld && expq.size() > 0) begin
            e = expq.pop_front();
            chk(res_data == e.res, {e.tag, " data"}, res_data, e.res);
            chk(flag_nv == e.nv, {e.tag, " nv"}, 64'(flag_nv), 64'(e.nv));
            chk(flag_nx == e.nx, {e.tag, " nx"}, 64'(flag_nx), 64'(e.nx));
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++; n_errors++;
        $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
        finish_run();
    end

    initial begin
        // R1: reset clears outputs even with op_vld high.
        op_vld = 1'b1; op_bits = 64'h3FF0000000000000;
        repeat (2) @(posedge clk);
        #1;
        chk(res_vld == 1'b0, "R1 reset valid", 64'(res_vld), 64'd0);
        chk(res_data == '0, "R1 reset data", res_data, 64'd0);
        chk(!flag_nv && !flag_nx, "R1 reset flags", {62'd0, flag_nv, flag_nx}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1; op_vld = 1'b0;

        step(1, 64'h3FF0000000000000, 3'd0, "R2 one");
        step(1, 64'h41E0000000000000, 3'd0, "R2 two31");
        step(0, 64'h41E0000000000000, 3'd0, "R1 idle");
        step(1, 64'h41EFFFFFFFE00000, 3'd1, "R2 max word");
        step(1, 64'h4004000000000000, 3'd0, "R3 2.5 even");
        step(1, 64'h4004000000000000, 3'd1, "R3 2.5 zero");
        step(1, 64'h4004000000000000, 3'd2, "R3 2.5 down");
        step(1, 64'h4004000000000000, 3'd3, "R3 2.5 up");
        step(1, 64'h4004000000000000, 3'd4, "R3 2.5 max");
        step(1, 64'h400C000000000000, 3'd0, "R3 3.5 even");
        step(1, 64'h41EFFFFFFFF00000, 3'd0, "R4 round carry");
        step(1, 64'h41EFFFFFFFF00000, 3'd1, "R8 trunc max");
        step(1, 64'h41F0000000000000, 3'd1, "R4 two32");
        step(1, 64'h7E37E43C8800759C, 3'd3, "R4 huge");
        step(1, 64'h7FF8000000000000, 3'd0, "R5 qnan");
        step(1, 64'hFFF0000000000001, 3'd1, "R5 neg nan");
        step(1, 64'h7FF0000000000000, 3'd2, "R5 pinf");
        step(1, 64'hFFF0000000000000, 3'd2, "R6 ninf");
        step(1, 64'hBFF0000000000000, 3'd1, "R6 minus one");
        step(1, 64'hBFD0000000000000, 3'd2, "R6 neg down");
        step(1, 64'hBFE0000000000000, 3'd0, "R7 neg half even");
        step(1, 64'hBFD0000000000000, 3'd3, "R7 neg up");
        step(1, 64'h8000000000000000, 3'd0, "R7 neg zero");
        step(1, 64'h3FD0000000000000, 3'd3, "R8 quarter up");
        step(1, 64'h0000000000000001, 3'd3, "R8 subnormal up");
        step(1, 64'h0000000000000001, 3'd2, "R8 subnormal down");
        step(1, 64'h3FF0000000000000, 3'd5, "R9 code5");
        step(1, 64'hBFF0000000000000, 3'd6, "R9 code6");
        step(1, 64'h0000000000000000, 3'd7, "R9 code7");
        step(1, 64'h41DFFFFFFFC00001, 3'd3, "R10 case one");
        chk(res_data == 64'hFFFFFFFF80000000, "R10 literal one", res_data, 64'hFFFFFFFF80000000);
        step(1, 64'h41EFFFFFFFFFFFFF, 3'd4, "R10 case two");
        chk(res_data == 64'hFFFFFFFFFFFFFFFF && flag_nv, "R10 literal two",
            res_data, 64'hFFFFFFFFFFFFFFFF);

        // R3 R4 R6 R8: random operands near the 32-bit boundary.
        for (int i = 0; i < 3000; i++) begin
            logic [63:0] b;
            logic [2:0]  m;
            logic [10:0] ex;
            b  = {$urandom, $urandom};
            ex = (i % 8 == 0) ? b[62:52] : 11'(1016 + $urandom_range(0, 40));
            b[62:52] = ex;
            if (i % 3 == 0) b[20:0] = '0;
            m = (i % 10 == 0) ? 3'($urandom_range(0, 7)) : 3'($urandom_range(0, 4));
            step((i % 7) != 3, b, m, "R3 random");
        end
        step(0, 64'd0, 3'd0, "R1 drain");
        finish_run();
    end
endmodule